// File: doc/BRIEF.md
# Injected/Regular Conversion Channel Scheduler

This block decides which of four multiplexed input channels a sigma-delta filter front end converts next. Two request classes compete. The injected class works on a group of channels chosen by a 4-bit mask. It runs either as a scan, which converts the whole group in one pass, or one channel per request, with a rotating pointer. The regular class works on a single channel chosen by a 2-bit index. It runs once or repeats for as long as the continuous bit is held.

The filter datapath reports the end of each conversion with a one-cycle done pulse. The scheduler presents the active channel, a busy flag and an injected/regular tag. It also gives a one-cycle completion pulse that carries the channel and the tag of the conversion that just finished. Clearing the filter enable stops everything.

Top module: `conv_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o`, `cmpl_o` and `act_inj_o` are 0.
- R2: In scan mode (`inj_scan_i`=1), one injected request converts every channel whose mask bit is set (bit y = channel y). Channels go in ascending order, lowest first. Each ends in a completion pulse tagged injected (`cmpl_inj_o`=1). The block is idle after the highest one.
- R3: In single mode (`inj_scan_i`=0), one injected request converts only the channel at the pointer. The pointer then moves to the next higher selected channel and wraps from the highest to the lowest.
- R4: A mask write (`inj_mask_wr_i`=1) while `inj_scan_i`=0 moves the pointer to the lowest selected channel of the new mask.
- R5: `inj_trig_i` and `inj_sw_start_i` each launch an injected request. Only `reg_sw_start_i` launches a regular conversion. In every case `busy_o` rises in the cycle after the strobe.
- R6: A regular start converts the channel `reg_ch_i` held at the strobe, tagged regular (`act_inj_o`=0). If `reg_cont_i`=0 when it completes, the block goes idle and stays idle.
- R7: With `reg_cont_i`=1 the regular conversion restarts on the latched channel one idle cycle after each completion, even if `reg_ch_i` has changed since.
- R8: An injected request that arrives during a regular conversion aborts it without a completion pulse. The regular sequence resumes on the same channel after the injected work ends. A running injected conversion is never interrupted by a regular request.
- R9: A done pulse is ignored while the active channel's bit in `ch_en_i` is 0. The conversion stays busy until a done pulse arrives with the channel enabled.
- R10: One clock after `flt_en_i` goes low, `busy_o` and `cmpl_o` are 0 and all pending requests are dropped. Strobes seen while it is low are ignored.
- R11: An injected request with an all-zero mask converts nothing. `busy_o` stays 0.
- R12: `cmpl_o` is high for exactly the cycle after an accepted done pulse. `cmpl_ch_o` and `cmpl_inj_o` hold the channel and tag of the conversion that finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flt_en_i | input | 1 | Filter enable; low aborts and clears |
| inj_mask_i | input | 4 | Injected group mask, bit y selects channel y |
| inj_mask_wr_i | input | 1 | Strobe marking a write of the injected mask |
| inj_scan_i | input | 1 | 1 = scan whole group, 0 = one channel per request |
| reg_ch_i | input | 2 | Regular channel index |
| reg_cont_i | input | 1 | Regular conversions repeat while 1 |
| inj_sw_start_i | input | 1 | Software injected start strobe |
| inj_trig_i | input | 1 | Hardware injected trigger strobe |
| reg_sw_start_i | input | 1 | Software regular start strobe |
| ch_en_i | input | 4 | Per-channel enable |
| conv_done_i | input | 1 | End-of-conversion pulse from the filter |
| act_ch_o | output | 2 | Channel being converted |
| busy_o | output | 1 | A conversion is active |
| act_inj_o | output | 1 | Active conversion is injected (1) or regular (0) |
| cmpl_o | output | 1 | One-cycle completion pulse |
| cmpl_ch_o | output | 2 | Channel of the completed conversion |
| cmpl_inj_o | output | 1 | Tag of the completed conversion |

## Verification
The properties assume that every input is synchronous to `clk_i`. They also assume that a done pulse refers to the channel shown on `act_ch_o` in that same cycle, so a pulse counts only as the end of the conversion currently presented. The stimulus keeps to this. Every strobe, mask write and done pulse is one cycle wide and is driven between clock edges. Done pulses are raised only while a conversion is visible, or on purpose while the active channel is disabled. The mask, the scan bit and the regular index are changed only in cycles where the property being exercised does not read them.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INJ  = 2'd1,
    ST_REG  = 2'd2
  } sched_st_e;
endpackage

// File: rtl/conv_sched_find.sv
// First set mask bit at or above start_i; optional wrap-around.
module conv_sched_find #(
  parameter int N_CH = 4,
  localparam int CW = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] mask_i,
  input  logic [CW:0]     start_i,
  input  logic            wrap_i,
  output logic            found_o,
  output logic [CW-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N_CH - 1; k >= 0; k--) begin
      int p;
      p = int'(start_i) + k;
      if (wrap_i) p = p % N_CH;
      if (p < N_CH && mask_i[p[CW-1:0]]) begin
        found_o = 1'b1;
        idx_o   = p[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/conv_sched_ptr.sv
// Single-mode rotating pointer.
module conv_sched_ptr #(
  parameter int N_CH = 4,
  localparam int CW = $clog2(N_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_wr_i,
  input  logic          scan_i,
  input  logic          low_found_i,
  input  logic [CW-1:0] low_idx_i,
  input  logic          adv_i,
  input  logic [CW-1:0] adv_idx_i,
  output logic [CW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
    end else if (mask_wr_i && !scan_i) begin
      ptr_o <= low_found_i ? low_idx_i : '0;
    end else if (adv_i) begin
      ptr_o <= adv_idx_i;
    end
  end
endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int CW = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flt_en_i,
  input  logic [N_CH-1:0] inj_mask_i,
  input  logic            inj_mask_wr_i,
  input  logic            inj_scan_i,
  input  logic [CW-1:0]   reg_ch_i,
  input  logic            reg_cont_i,
  input  logic            inj_sw_start_i,
  input  logic            inj_trig_i,
  input  logic            reg_sw_start_i,
  input  logic [N_CH-1:0] ch_en_i,
  input  logic            conv_done_i,
  output logic [CW-1:0]   act_ch_o,
  output logic            busy_o,
  output logic            act_inj_o,
  output logic            cmpl_o,
  output logic [CW-1:0]   cmpl_ch_o,
  output logic            cmpl_inj_o
);
  sched_st_e       st_q;
  logic [N_CH-1:0] inj_mask_q;
  logic            inj_scan_q;
  logic            inj_pend_q;
  logic            reg_pend_q;
  logic [CW-1:0]   reg_ch_q;
  logic [CW-1:0]   ptr;

  logic            low_found, sgl_found, scn_found, rot_found;
  logic [CW-1:0]   low_idx, sgl_idx, scn_idx, rot_idx;
  logic [CW:0]     after_act;

  logic inj_strobe, inj_go, inj_ok, reg_go, done_ok;
  logic [CW-1:0] reg_ch_w, inj_first;

  assign after_act  = {1'b0, act_ch_o} + 1'b1;
  assign inj_strobe = inj_sw_start_i | inj_trig_i;
  assign inj_go     = inj_strobe | inj_pend_q;
  assign inj_ok     = inj_scan_i ? low_found : sgl_found;
  assign inj_first  = inj_scan_i ? low_idx : sgl_idx;
  assign reg_go     = reg_sw_start_i | reg_pend_q;
  assign reg_ch_w   = reg_sw_start_i ? reg_ch_i : reg_ch_q;
  assign done_ok    = conv_done_i && ch_en_i[act_ch_o] && (st_q != ST_IDLE);

  conv_sched_find #(.N_CH(N_CH)) u_find_low (
    .mask_i(inj_mask_i), .start_i('0), .wrap_i(1'b0),
    .found_o(low_found), .idx_o(low_idx));
  conv_sched_find #(.N_CH(N_CH)) u_find_sgl (
    .mask_i(inj_mask_i), .start_i({1'b0, ptr}), .wrap_i(1'b1),
    .found_o(sgl_found), .idx_o(sgl_idx));
  conv_sched_find #(.N_CH(N_CH)) u_find_scn (
    .mask_i(inj_mask_q), .start_i(after_act), .wrap_i(1'b0),
    .found_o(scn_found), .idx_o(scn_idx));
  conv_sched_find #(.N_CH(N_CH)) u_find_rot (
    .mask_i(inj_mask_q), .start_i(after_act), .wrap_i(1'b1),
    .found_o(rot_found), .idx_o(rot_idx));

  conv_sched_ptr #(.N_CH(N_CH)) u_ptr (
    .clk_i, .rst_ni,
    .mask_wr_i(inj_mask_wr_i), .scan_i(inj_scan_i),
    .low_found_i(low_found), .low_idx_i(low_idx),
    .adv_i(flt_en_i && st_q == ST_INJ && !inj_scan_q && done_ok && rot_found),
    .adv_idx_i(rot_idx), .ptr_o(ptr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      inj_mask_q <= '0;
      inj_scan_q <= 1'b0;
      inj_pend_q <= 1'b0;
      reg_pend_q <= 1'b0;
      reg_ch_q   <= '0;
      act_ch_o   <= '0;
      cmpl_o     <= 1'b0;
      cmpl_ch_o  <= '0;
      cmpl_inj_o <= 1'b0;
    end else if (!flt_en_i) begin
      st_q       <= ST_IDLE;
      inj_pend_q <= 1'b0;
      reg_pend_q <= 1'b0;
      cmpl_o     <= 1'b0;
    end else begin
      cmpl_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (inj_go) begin
            inj_pend_q <= 1'b0;
            if (inj_ok) begin
              st_q       <= ST_INJ;
              act_ch_o   <= inj_first;
              inj_mask_q <= inj_mask_i;
              inj_scan_q <= inj_scan_i;
            end
          end else if (reg_go) begin
            st_q     <= ST_REG;
            act_ch_o <= reg_ch_w;
          end
        end
        ST_REG: begin
          if (inj_go) begin
            // injected preempts; regular job stays pending
            inj_pend_q <= 1'b0;
            if (inj_ok) begin
              st_q       <= ST_INJ;
              act_ch_o   <= inj_first;
              inj_mask_q <= inj_mask_i;
              inj_scan_q <= inj_scan_i;
            end
          end else if (done_ok) begin
            cmpl_o     <= 1'b1;
            cmpl_ch_o  <= act_ch_o;
            cmpl_inj_o <= 1'b0;
            st_q       <= ST_IDLE;
            if (!reg_cont_i) reg_pend_q <= 1'b0;
          end
        end
        ST_INJ: begin
          if (inj_strobe) inj_pend_q <= 1'b1;
          if (done_ok) begin
            cmpl_o     <= 1'b1;
            cmpl_ch_o  <= act_ch_o;
            cmpl_inj_o <= 1'b1;
            if (inj_scan_q && scn_found) act_ch_o <= scn_idx;
            else                         st_q     <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (reg_sw_start_i) begin
        reg_pend_q <= 1'b1;
        reg_ch_q   <= reg_ch_i;
      end
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign act_inj_o = (st_q == ST_INJ);
endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk #(
  parameter int N_CH = 4,
  localparam int CW = $clog2(N_CH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            flt_en_i,
  input logic            conv_done_i,
  input logic [N_CH-1:0] ch_en_i,
  input logic [CW-1:0]   act_ch_o,
  input logic            busy_o,
  input logic            act_inj_o,
  input logic            cmpl_o,
  input logic [CW-1:0]   cmpl_ch_o,
  input logic            cmpl_inj_o
);
  // R10
  en_low_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_en_i |=> !busy_o && !cmpl_o);

  // R12
  cmpl_follows_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_o |-> $past(busy_o) && $past(conv_done_i) && cmpl_ch_o == $past(act_ch_o)
               && cmpl_inj_o == $past(act_inj_o));

  // R9
  disabled_ch_stalls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ch_en_i[act_ch_o] |=> !cmpl_o);

  // R8
  inj_not_interrupted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && act_inj_o && !conv_done_i && flt_en_i
      |=> busy_o && act_inj_o && $stable(act_ch_o));

  // R1
  idle_has_no_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !act_inj_o);
endmodule

bind conv_sched conv_sched_chk #(.N_CH(N_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flt_en_i(flt_en_i), .conv_done_i(conv_done_i),
  .ch_en_i(ch_en_i), .act_ch_o(act_ch_o), .busy_o(busy_o), .act_inj_o(act_inj_o),
  .cmpl_o(cmpl_o), .cmpl_ch_o(cmpl_ch_o), .cmpl_inj_o(cmpl_inj_o));

// File: tb/conv_sched_bench.sv
module conv_sched_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       flt_en_i = 1'b1;
  logic [3:0] inj_mask_i = '0;
  logic       inj_mask_wr_i = 1'b0;
  logic       inj_scan_i = 1'b0;
  logic [1:0] reg_ch_i = '0;
  logic       reg_cont_i = 1'b0;
  logic       inj_sw_start_i = 1'b0;
  logic       inj_trig_i = 1'b0;
  logic       reg_sw_start_i = 1'b0;
  logic [3:0] ch_en_i = 4'hf;
  logic       conv_done_i = 1'b0;
  logic [1:0] act_ch_o, cmpl_ch_o;
  logic       busy_o, act_inj_o, cmpl_o, cmpl_inj_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  conv_sched u_conv_sched (.*);

  typedef struct packed {
    logic [3:0] mask;
    logic [2:0] cnt;
    logic [7:0] seq;  // seq[1:0] is the first channel
  } scan_vec_t;

  localparam scan_vec_t VECS [4] = '{
    '{mask: 4'b1011, cnt: 3'd3, seq: 8'b00_11_01_00},
    '{mask: 4'b0100, cnt: 3'd1, seq: 8'b00_00_00_10},
    '{mask: 4'b1111, cnt: 3'd4, seq: 8'b11_10_01_00},
    '{mask: 4'b1010, cnt: 3'd2, seq: 8'b00_00_11_01}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic pulse_inj();
    inj_sw_start_i = 1'b1; step(); inj_sw_start_i = 1'b0;
  endtask

  task automatic pulse_reg();
    reg_sw_start_i = 1'b1; step(); reg_sw_start_i = 1'b0;
  endtask

  task automatic pulse_done();
    conv_done_i = 1'b1; step(); conv_done_i = 1'b0;
  endtask

  task automatic wr_mask(input logic [3:0] m, input logic scan);
    inj_mask_i = m; inj_scan_i = scan; inj_mask_wr_i = 1'b1;
    step(); inj_mask_wr_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    step(); step();
    check("R1 busy in reset", busy_o, 0);
    check("R1 cmpl in reset", cmpl_o, 0);
    rst_ni = 1'b1;
    step();
    check("R1 busy after reset", busy_o, 0);
    check("R1 tag after reset", act_inj_o, 0);

    // R2: scan table
    for (int v = 0; v < 4; v++) begin
      wr_mask(VECS[v].mask, 1'b1);
      pulse_inj();
      check("R5 busy after sw start", busy_o, 1);
      check("R2 injected tag", act_inj_o, 1);
      check("R2 first channel", act_ch_o, int'(VECS[v].seq[1:0]));
      for (int i = 0; i < int'(VECS[v].cnt); i++) begin
        pulse_done();
        check("R12 cmpl pulse", cmpl_o, 1);
        check("R2 cmpl channel", cmpl_ch_o, int'(VECS[v].seq[2*i +: 2]));
        check("R12 cmpl tag", cmpl_inj_o, 1);
        if (i < int'(VECS[v].cnt) - 1)
          check("R2 next channel", act_ch_o, int'(VECS[v].seq[2*i+2 +: 2]));
        else
          check("R2 idle at end", busy_o, 0);
      end
      step();
      check("R12 pulse one cycle", cmpl_o, 0);
    end

    // R3 single mode rotation over mask 1010
    wr_mask(4'b1010, 1'b0);
    pulse_inj();
    check("R3 single first", act_ch_o, 1);
    pulse_done();
    check("R3 single stops", busy_o, 0);
    pulse_inj();
    check("R3 single advance", act_ch_o, 3);
    pulse_done();
    pulse_inj();
    check("R3 single wrap", act_ch_o, 1);
    pulse_done();
    // pointer now 3; R4 mask write resets to lowest
    wr_mask(4'b1110, 1'b0);
    pulse_inj();
    check("R4 pointer reset", act_ch_o, 1);
    pulse_done();

    // R5 trigger start
    wr_mask(4'b0100, 1'b1);
    inj_trig_i = 1'b1; step(); inj_trig_i = 1'b0;
    check("R5 trigger busy", busy_o, 1);
    check("R5 trigger channel", act_ch_o, 2);
    pulse_done();

    // R11 zero mask
    wr_mask(4'b0000, 1'b1);
    inj_trig_i = 1'b1; step(); inj_trig_i = 1'b0;
    step();
    check("R11 zero mask idle", busy_o, 0);

    // R6 single regular
    reg_ch_i = 2'd2; reg_cont_i = 1'b0;
    pulse_reg();
    check("R5 reg busy", busy_o, 1);
    check("R6 reg tag", act_inj_o, 0);
    check("R6 reg channel", act_ch_o, 2);
    pulse_done();
    check("R6 cmpl channel", cmpl_ch_o, 2);
    check("R6 cmpl tag", cmpl_inj_o, 0);
    step(); step();
    check("R6 stays idle", busy_o, 0);

    // R7 continuous regular
    reg_ch_i = 2'd3; reg_cont_i = 1'b1;
    pulse_reg();
    check("R7 reg channel", act_ch_o, 3);
    reg_ch_i = 2'd0;
    pulse_done();
    check("R7 idle gap", busy_o, 0);
    step();
    check("R7 restart", busy_o, 1);
    check("R7 latched channel", act_ch_o, 3);

    // R8 preemption and resume
    wr_mask(4'b0001, 1'b1);
    pulse_inj();
    check("R8 preempt tag", act_inj_o, 1);
    check("R8 preempt channel", act_ch_o, 0);
    check("R8 no cmpl on abort", cmpl_o, 0);
    pulse_done();
    check("R8 inj cmpl", cmpl_inj_o, 1);
    step();
    check("R8 resume busy", busy_o, 1);
    check("R8 resume tag", act_inj_o, 0);
    check("R8 resume channel", act_ch_o, 3);
    reg_cont_i = 1'b0;
    pulse_done();
    step();
    check("R8 final idle", busy_o, 0);

    // R9 disabled channel stalls
    ch_en_i = 4'b1011;
    reg_ch_i = 2'd2;
    pulse_reg();
    pulse_done();
    check("R9 no cmpl disabled", cmpl_o, 0);
    check("R9 still busy", busy_o, 1);
    ch_en_i = 4'hf;
    pulse_done();
    check("R9 cmpl after enable", cmpl_o, 1);
    check("R9 cmpl channel", cmpl_ch_o, 2);

    // R10 filter enable clear
    reg_ch_i = 2'd1; reg_cont_i = 1'b1;
    pulse_reg();
    check("R10 running", busy_o, 1);
    flt_en_i = 1'b0;
    step();
    check("R10 busy cleared", busy_o, 0);
    pulse_inj();
    check("R10 strobe ignored", busy_o, 0);
    flt_en_i = 1'b1;
    step(); step();
    check("R10 pending dropped", busy_o, 0);

    finish_run();
  end
endmodule